// File: doc/BRIEF.md
# Multi-Bank RAM Zero-Fill and Parity Controller

This block fronts a set of parity-protected RAM banks with one 32-bit control register and a fill sequencer for each bank. For every bank the register holds two bits, placed side by side. One is a write-only trigger that starts a zero-fill of the whole bank. The other is a sticky test switch that turns parity protection off for that bank's normal accesses.

A fill writes one address per clock, going from address 0 up to the last address. Each word it writes is all zeros, and its check bit is computed from both the data and the address, so a later read with protection on sees a clean word. While a bank is filling it reports busy and refuses access: its ready output is low. When the fill ends, the bank raises a sticky done flag. That flag clears only when the bank's next fill starts. Banks run independently, and any number of them can fill at the same time.

With protection on, a write stores a check bit equal to the XOR of the even parity of the data word and the even parity of the address. A read compares the stored bit against the same function and flags a mismatch. With the test switch on, a write stores the check bit the caller supplies, and a read returns the raw stored check bit with the error flag held low. Software uses this to plant errors and to inspect check bits.

Top module: `ram_init_ctrl`

## Requirements
- R1: After a synchronous reset, every test bit is 0, `reg_rdata` reads 0, no bank is busy or done, and every bank's `acc_ready` is 1.
- R2: Register bit 2k+1 is bank k's test bit (bank 0 on bit 1, bank 3 on bit 7). It reads back as written one cycle after the write. Even bits always read 0. Bits 31 to 8 read 0 and ignore writes.
- R3: Writing 1 to register bit 2k starts a fill of bank k. A 0 in that bit has no effect and leaves the bank idle.
- R4: A fill writes data 0 with check bit equal to the parity of the address to every address 0 to DEPTH-1, one per cycle. Busy stays high for exactly DEPTH cycles.
- R5: A bank's done flag rises when its fill completes, stays set, and clears when that bank's next fill starts.
- R6: A start request for a bank that is already filling is ignored. The running fill neither restarts nor stretches.
- R7: Several banks started in the same write fill concurrently and finish together.
- R8: While a bank is busy, its `acc_ready` is 0. A request to that bank is not performed: it stores nothing and returns no read response.
- R9: With protection on, a write stores check bit = parity(data) XOR parity(addr) and ignores `acc_wchk`. A read returns the data and the check bit one cycle after acceptance, with `acc_err` 0.
- R10: With protection on, a read of a word whose stored check bit differs from parity(data) XOR parity(addr) raises `acc_err` together with `acc_rvalid`.
- R11: With a bank's test bit set, a write stores `acc_wchk` as the check bit. A read returns the raw stored check bit, and `acc_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read view (registered) |
| bank_busy | output | NUM_BANKS | Per-bank fill in progress |
| bank_done | output | NUM_BANKS | Per-bank sticky fill complete |
| acc_req | input | NUM_BANKS | Per-bank access request |
| acc_we | input | NUM_BANKS | Per-bank write (1) or read (0) |
| acc_addr | input | NUM_BANKS*ADDR_W | Per-bank word address |
| acc_wdata | input | NUM_BANKS*DATA_W | Per-bank write data |
| acc_wchk | input | NUM_BANKS | Per-bank check bit used in test mode |
| acc_ready | output | NUM_BANKS | Per-bank request accepted when high |
| acc_rvalid | output | NUM_BANKS | Per-bank read response valid |
| acc_rdata | output | NUM_BANKS*DATA_W | Per-bank read data |
| acc_rchk | output | NUM_BANKS | Per-bank stored check bit |
| acc_err | output | NUM_BANKS | Per-bank parity mismatch on read |

## Verification
A fill counter stuck or wrapping early shows up immediately as a busy window that is not exactly DEPTH cycles long. It also leaves addresses whose read check bit disagrees with the address parity, and that is caught on the first sweep of the bank. A wrong check-bit source, such as address parity dropped or the test switch not honoured, surfaces on the very next read as a wrong `acc_rchk` or a spurious or missing `acc_err`. A leaked stall or a lost done flag is visible on the port in the cycle the fill starts or ends.

// File: rtl/ram_init_pkg.sv
package ram_init_pkg;
  localparam int unsigned REG_W = 32;

  // Per-bank control pair: the start trigger sits on the even bit, the test switch on the odd bit.
  function automatic int unsigned start_pos(input int unsigned bank);
    return 2 * bank;
  endfunction

  function automatic int unsigned test_pos(input int unsigned bank);
    return 2 * bank + 1;
  endfunction
endpackage

// File: rtl/ric_regs.sv
module ric_regs
  import ram_init_pkg::*;
#(
  parameter int unsigned NB = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [NB-1:0]    test_mode,
  output logic [NB-1:0]    start_go,
  output logic [REG_W-1:0] rdata
);
  logic [NB-1:0] test_q, test_d;

  always_comb begin
    test_d = test_q;
    for (int k = 0; k < NB; k++) begin
      start_go[k] = wr & wdata[start_pos(k)];
      if (wr) test_d[k] = wdata[test_pos(k)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      test_q <= '0;
      rdata  <= '0;
    end else begin
      test_q <= test_d;
      rdata  <= '0;
      for (int k = 0; k < NB; k++) rdata[test_pos(k)] <= test_d[k];
    end
  end

  assign test_mode = test_q;
endmodule

// File: rtl/ric_mem.sv
module ric_mem #(
  parameter int unsigned W  = 17,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned DEPTH = 2 ** AW;
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/ric_bank.sv
module ric_bank #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_go,
  input  logic          test_mode,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wchk,
  output logic          ready,
  output logic          busy,
  output logic          done,
  output logic          rvalid,
  output logic [DW-1:0] rdata,
  output logic          rchk,
  output logic          err
);
  localparam int unsigned WW = DW + 1;

  logic [AW-1:0] fill_cnt;
  logic          busy_q, done_q;
  logic          accept, m_we, m_re;
  logic [AW-1:0] m_waddr;
  logic [WW-1:0] m_wword, m_rword;
  logic          new_chk;
  logic          rvalid_q, rd_test_q;
  logic [AW-1:0] rd_addr_q;

  // Fill sequencer: one address per clock, restart requests ignored while running.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fill_cnt <= '0;
    end else if (busy_q) begin
      fill_cnt <= fill_cnt + 1'b1;
      if (&fill_cnt) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else if (start_go) begin
      busy_q   <= 1'b1;
      done_q   <= 1'b0;
      fill_cnt <= '0;
    end
  end

  assign accept  = req & ~busy_q;
  assign new_chk = test_mode ? wchk : ((^wdata) ^ (^addr));

  always_comb begin
    if (busy_q) begin
      m_we    = 1'b1;
      m_waddr = fill_cnt;
      m_wword = {^fill_cnt, {DW{1'b0}}};
    end else begin
      m_we    = accept & we;
      m_waddr = addr;
      m_wword = {new_chk, wdata};
    end
  end

  assign m_re = accept & ~we;

  ric_mem #(.W(WW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (m_we),
    .waddr (m_waddr),
    .wdata (m_wword),
    .re    (m_re),
    .raddr (addr),
    .rdata (m_rword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      rd_test_q <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rvalid_q <= m_re;
      if (m_re) begin
        rd_test_q <= test_mode;
        rd_addr_q <= addr;
      end
    end
  end

  assign ready  = ~busy_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign rvalid = rvalid_q;
  assign rdata  = m_rword[DW-1:0];
  assign rchk   = m_rword[DW];
  assign err    = rvalid_q & ~rd_test_q &
                  (m_rword[DW] != ((^m_rword[DW-1:0]) ^ (^rd_addr_q)));
endmodule

// File: rtl/ram_init_ctrl.sv
module ram_init_ctrl
  import ram_init_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic [REG_W-1:0]              reg_wdata,
  output logic [REG_W-1:0]              reg_rdata,
  output logic [NUM_BANKS-1:0]          bank_busy,
  output logic [NUM_BANKS-1:0]          bank_done,
  input  logic [NUM_BANKS-1:0]          acc_req,
  input  logic [NUM_BANKS-1:0]          acc_we,
  input  logic [NUM_BANKS*ADDR_W-1:0]   acc_addr,
  input  logic [NUM_BANKS*DATA_W-1:0]   acc_wdata,
  input  logic [NUM_BANKS-1:0]          acc_wchk,
  output logic [NUM_BANKS-1:0]          acc_ready,
  output logic [NUM_BANKS-1:0]          acc_rvalid,
  output logic [NUM_BANKS*DATA_W-1:0]   acc_rdata,
  output logic [NUM_BANKS-1:0]          acc_rchk,
  output logic [NUM_BANKS-1:0]          acc_err
);
  logic [NUM_BANKS-1:0] test_mode, start_go;

  ric_regs #(.NB(NUM_BANKS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .test_mode (test_mode),
    .start_go  (start_go),
    .rdata     (reg_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ric_bank #(.DW(DATA_W), .AW(ADDR_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .start_go  (start_go[b]),
      .test_mode (test_mode[b]),
      .req       (acc_req[b]),
      .we        (acc_we[b]),
      .addr      (acc_addr[b*ADDR_W +: ADDR_W]),
      .wdata     (acc_wdata[b*DATA_W +: DATA_W]),
      .wchk      (acc_wchk[b]),
      .ready     (acc_ready[b]),
      .busy      (bank_busy[b]),
      .done      (bank_done[b]),
      .rvalid    (acc_rvalid[b]),
      .rdata     (acc_rdata[b*DATA_W +: DATA_W]),
      .rchk      (acc_rchk[b]),
      .err       (acc_err[b])
    );
  end
endmodule

// File: rtl/ram_init_chk.sv
module ram_init_chk #(
  parameter int unsigned NB = 4,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [31:0]   reg_rdata,
  input logic [NB-1:0] bank_busy,
  input logic [NB-1:0] bank_done,
  input logic [NB-1:0] acc_req,
  input logic [NB-1:0] acc_rvalid,
  input logic [NB-1:0] acc_err
);
  localparam int unsigned DEPTH = 2 ** AW;
  localparam logic [31:0] ZERO_MASK = ~{16{2'b10}};

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ZERO_MASK) == 32'h0);

  for (genvar i = 0; i < NB; i++) begin : g_chk
    logic [AW:0] run_len;
    always_ff @(posedge clk) begin
      if (rst) run_len <= '0;
      else if (bank_busy[i]) run_len <= run_len + 1'b1;
      else run_len <= '0;
    end

    // R4
    fill_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(bank_busy[i]) |-> run_len == (AW+1)'(DEPTH));
    // R5
    done_on_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(bank_busy[i]) |-> bank_done[i]);
    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bank_busy[i]) |-> !bank_done[i]);
    // R8
    stall_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
      (bank_busy[i] && acc_req[i]) |=> !acc_rvalid[i]);
    // R10
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
      acc_err[i] |-> acc_rvalid[i]);
  end
endmodule

bind ram_init_ctrl ram_init_chk #(.NB(NUM_BANKS), .AW(ADDR_W)) u_ram_init_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rdata  (reg_rdata),
  .bank_busy  (bank_busy),
  .bank_done  (bank_done),
  .acc_req    (acc_req),
  .acc_rvalid (acc_rvalid),
  .acc_err    (acc_err)
);

// File: tb/test_ram_init_ctrl.sv
module test_ram_init_ctrl;
  localparam int NB = 4, AW = 4, DW = 16, DEPTH = 16;

  logic clk = 0, rst = 1;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NB-1:0] bank_busy, bank_done, acc_req = '0, acc_we = '0, acc_wchk = '0;
  logic [NB-1:0] acc_ready, acc_rvalid, acc_rchk, acc_err;
  logic [NB*AW-1:0] acc_addr = '0;
  logic [NB*DW-1:0] acc_wdata = '0, acc_rdata;
  int n_chk = 0, n_bad = 0;
  int busy_cnt [NB];

  always #5 clk = ~clk;

  ram_init_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) i_ram_init_ctrl (.*);

  always @(negedge clk) for (int b = 0; b < NB; b++) if (bank_busy[b]) busy_cnt[b]++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic reg_write(logic [31:0] v);
    reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic acc(int b, logic w, logic [AW-1:0] a, logic [DW-1:0] d, logic c);
    acc_req[b] = 1; acc_we[b] = w; acc_addr[b*AW +: AW] = a;
    acc_wdata[b*DW +: DW] = d; acc_wchk[b] = c;
    @(negedge clk);
    acc_req[b] = 0; acc_we[b] = 0;
  endtask

  // returns {err, rvalid, chk, data}
  function automatic logic [31:0] rd_view(int b);
    return {13'b0, acc_err[b], acc_rvalid[b], acc_rchk[b], acc_rdata[b*DW +: DW]};
  endfunction

  function automatic logic par(logic [31:0] v);
    return 1'($countones(v) % 2);
  endfunction

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 16'h1111) ^ 16'h5A3C);
  endfunction

  task automatic clear_counts();
    #1;
    for (int b = 0; b < NB; b++) busy_cnt[b] = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 busy", 32'(bank_busy), 0);
    chk("R1 done", 32'(bank_done), 0);
    chk("R1 ready", 32'(acc_ready), 32'hF);

    // R2 layout and reserved bits; R3 zero start bits do nothing
    reg_write(32'hFFFF_FFAA);
    chk("R2 all test bits", reg_rdata, 32'h0000_00AA);
    chk("R3 no start on 0", 32'(bank_busy), 0);
    reg_write(32'h0000_0022);
    chk("R2 banks 0,2 test", reg_rdata, 32'h0000_0022);
    reg_write(32'h0000_0000);
    chk("R2 cleared", reg_rdata, 0);

    // R7 all banks start together; R4 busy length
    clear_counts();
    reg_write(32'h0000_0055);
    chk("R2 start bits read 0", reg_rdata, 0);
    chk("R7 all busy", 32'(bank_busy), 32'hF);
    repeat (DEPTH + 4) @(negedge clk);
    for (int b = 0; b < NB; b++) chk($sformatf("R4 busy len bank%0d", b), busy_cnt[b], DEPTH);
    chk("R5 all done", 32'(bank_done), 32'hF);
    chk("R7 none busy", 32'(bank_busy), 0);

    // R4 sweep of filled contents
    for (int b = 0; b < NB; b++)
      for (int a = 0; a < DEPTH; a++) begin
        acc(b, 0, AW'(a), '0, 0);
        chk($sformatf("R4 fill b%0d a%0d", b, a), rd_view(b), {13'b0, 1'b0, 1'b1, par(a), 16'h0});
      end

    // R9 protected writes ignore acc_wchk
    for (int a = 0; a < DEPTH; a++) acc(1, 1, AW'(a), pat(a), ~(par(32'(pat(a))) ^ par(a)));
    for (int a = 0; a < DEPTH; a++) begin
      acc(1, 0, AW'(a), '0, 0);
      chk($sformatf("R9 rd a%0d", a), rd_view(1),
          {13'b0, 1'b0, 1'b1, par(32'(pat(a))) ^ par(a), pat(a)});
    end

    // R11 test mode on bank 1: store supplied bad check bit, read raw
    reg_write(32'h0000_0008);
    acc(1, 1, 5, 16'h1234, ~(par(32'h1234) ^ par(5)));
    acc(1, 0, 5, '0, 0);
    chk("R11 raw chk no err", rd_view(1), {13'b0, 1'b0, 1'b1, ~(par(32'h1234) ^ par(5)), 16'h1234});
    // R10 protected read flags the mismatch
    reg_write(32'h0000_0000);
    acc(1, 0, 5, '0, 0);
    chk("R10 err", rd_view(1), {13'b0, 1'b1, 1'b1, ~(par(32'h1234) ^ par(5)), 16'h1234});

    // R3 R5 R6 R8 refill bank 1 only
    clear_counts();
    reg_write(32'h0000_0004);
    chk("R3 only bank1 busy", 32'(bank_busy), 32'h2);
    chk("R5 done cleared", 32'(bank_done), 32'hD);
    chk("R8 ready low", 32'(acc_ready), 32'hD);
    repeat (7) @(negedge clk);
    reg_write(32'h0000_0004);
    acc(1, 1, 3, 16'hABCD, 0);
    acc(1, 0, 2, '0, 0);
    chk("R8 no read resp", 32'(acc_rvalid[1]), 0);
    repeat (DEPTH) @(negedge clk);
    chk("R6 busy len unchanged", busy_cnt[1], DEPTH);
    chk("R5 done set", 32'(bank_done), 32'hF);
    acc(1, 0, 3, '0, 0);
    chk("R8 stalled write dropped", rd_view(1), {13'b0, 1'b0, 1'b1, par(3), 16'h0});
    acc(1, 0, 5, '0, 0);
    chk("R4 refill clears bad word", rd_view(1), {13'b0, 1'b0, 1'b1, par(5), 16'h0});
    summary();
  end
endmodule